// File: doc/BRIEF.md
# One-Wire ROM Search Sequencer

This block enumerates the devices sharing a one-wire bus. Each run finds one 64-bit device identifier using the binary-tree search with discrepancy tracking. A run starts with a bus reset and the search command. At every identifier position the block then reads the bit and its complement from the bus and writes back the direction it picks. Devices whose bit differs from the written direction drop out of the run. The block does not generate slot timing itself. It hands each slot to a separate slot engine over a request channel and waits for that engine's response.

To list all devices, software starts the first run with a previous discrepancy of 0. It feeds each run's `next_disc` into the following run. A successful run that returns `next_disc == 0` has found the last device. The identifier found in one run stays in an internal register. The next run replays the lower-position choices from it.

Slot requests use valid/ready. `slot_valid` stays high with a constant `slot_kind` until the cycle in which `slot_ready` is high. The request transfers in that cycle. The engine may stall by holding `slot_ready` low for any number of cycles. The response comes back later as a one-cycle `slot_rsp_valid` pulse, and the sequencer always accepts it. It has no ready signal, and a pulse is only acted on after a request has been accepted.

Top module: `ow_rom_search`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `slot_valid` are 0, and `rom_id` and `next_disc` are all zeros.
- R2: A run started by `start` in idle issues a reset slot first. It then issues eight write slots carrying 0xF0, least-significant bit first, which is four write-0 slots followed by four write-1 slots. `slot_kind` encoding: 0 = reset, 1 = write 0, 2 = write 1, 3 = read.
- R3: For each position, from 0 up to 63, the block issues two read slots and then one write slot carrying the chosen bit. A complete run issues exactly 201 slots.
- R4: If both reads of a position return 1, the run stops after that pair with no write slot. `err` and `done` are then 1 and `next_disc` is 0; a failure at position 0 costs 11 slots in total.
- R5: If the two reads differ, identifier bit i takes the first read value, and that value is the one written.
- R6: If both reads return 0 at the position equal to the previous discrepancy, the block writes 1 and does not record that position.
- R7: If both reads return 0 at a position above the previous discrepancy, the block writes 0 and records the position.
- R8: If both reads return 0 at a position below the previous discrepancy, the block writes the bit that the previous run left at that position in `rom_id`. It records the position only when that bit is 0.
- R9: At the end of a successful run, `done` is 1 and `err` is 0. `next_disc` is the highest recorded position, or 0 if none was recorded. `rom_id[i]` holds position i, so `rom_id[7:0]` is the family byte. `done` reads 0 while a run is in progress.
- R10: A `start` pulse during a run is ignored, and so is the `prev_disc` value that comes with it.
- R11: While `slot_valid` is high and `slot_ready` is low, `slot_valid` stays high and `slot_kind` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| prev_disc | input | 6 | Discrepancy index returned by the previous run |
| slot_valid | output | 1 | Slot request pending |
| slot_ready | input | 1 | Slot engine accepts the request |
| slot_kind | output | 2 | Requested slot: 0 reset, 1 write 0, 2 write 1, 3 read |
| slot_rsp_valid | input | 1 | One-cycle pulse: the accepted slot has finished |
| slot_rsp_bit | input | 1 | Bus value sampled by a read slot |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run has ended; stays set until the next start |
| err | output | 1 | Last run ended because no device answered |
| rom_id | output | 64 | Identifier found (family byte in [7:0]) |
| next_disc | output | 6 | Discrepancy index to pass to the next run |

## Verification
A wrong choice at a position shows at the ports within one slot. The write slot that follows the read pair carries the wrong `slot_kind`, and from that point the modelled devices drop out differently, so the final `rom_id` differs too. A wrong recorded discrepancy or a corrupted replay bit stays hidden inside the run. It appears as a wrong `next_disc` at `done`, or as the wrong device on the following run. For this reason the scenarios chain runs over the same device population. A stalled handshake shows up as a changed `slot_kind` during back-pressure, or as a missing or extra slot in the 201-slot count.

// File: rtl/ows_pkg.sv
package ows_pkg;
  typedef enum logic [1:0] {
    SK_RESET = 2'd0,
    SK_WR0   = 2'd1,
    SK_WR1   = 2'd2,
    SK_READ  = 2'd3
  } slot_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RST, ST_RSTW, ST_CMD, ST_CMDW,
    ST_RDA, ST_RDAW, ST_RDB, ST_RDBW, ST_DIR, ST_DIRW
  } seq_state_e;
endpackage

// File: rtl/ows_decide.sv
module ows_decide #(
  parameter int IDX_W = 6
) (
  input  logic             bit_a,
  input  logic             bit_b,
  input  logic [IDX_W-1:0] pos,
  input  logic [IDX_W-1:0] prev,
  input  logic             old_bit,
  output logic             abort,
  output logic             choice,
  output logic             mark
);
  logic conflict;

  always_comb begin
    abort    = bit_a & bit_b;
    conflict = ~bit_a & ~bit_b;
    choice   = bit_a;
    mark     = 1'b0;
    if (conflict) begin
      if (pos == prev) begin
        choice = 1'b1;
      end else if (pos > prev) begin
        choice = 1'b0;
        mark   = 1'b1;
      end else begin
        choice = old_bit;
        mark   = ~old_bit;
      end
    end
  end
endmodule

// File: rtl/ows_disc_track.sv
module ows_disc_track #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cap_en,
  input  logic [IDX_W-1:0] cap_idx,
  output logic [IDX_W-1:0] disc_q
);
  // Positions arrive in ascending order, so the last capture is the highest.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      disc_q <= '0;
    else if (clear)  disc_q <= '0;
    else if (cap_en) disc_q <= cap_idx;
  end
endmodule

// File: rtl/ows_id_store.sv
module ows_id_store #(
  parameter int ID_W  = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit,
  output logic [ID_W-1:0]  id_q
);
  for (genvar i = 0; i < ID_W; i++) begin : g_bit
    logic b;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              b <= 1'b0;
      else if (wr_en && wr_idx == IDX_W'(i))   b <= wr_bit;
    end
    assign id_q[i] = b;
  end

  assign rd_bit = id_q[rd_idx];
endmodule

// File: rtl/ow_rom_search.sv
module ow_rom_search
  import ows_pkg::*;
#(
  parameter int         ID_W     = 64,
  parameter int         CMD_W    = 8,
  parameter logic [7:0] CMD_CODE = 8'hF0,
  localparam int        IDX_W    = $clog2(ID_W),
  localparam int        CIDX_W   = $clog2(CMD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] prev_disc,
  output logic             slot_valid,
  input  logic             slot_ready,
  output logic [1:0]       slot_kind,
  input  logic             slot_rsp_valid,
  input  logic             slot_rsp_bit,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [ID_W-1:0]  rom_id,
  output logic [IDX_W-1:0] next_disc
);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(ID_W - 1);
  localparam logic [IDX_W-1:0] LAST_CMD = IDX_W'(CMD_W - 1);

  seq_state_e       state;
  logic [IDX_W-1:0] pos;
  logic [IDX_W-1:0] prev_q;
  logic             bit_a_q;
  logic             dir_q;
  logic             done_q;
  logic             err_q;
  logic [IDX_W-1:0] disc_out_q;

  logic             abort, choice, mark, old_bit;
  logic             pair_in;
  logic [IDX_W-1:0] disc_run;
  slot_kind_e       kind;

  assign pair_in = (state == ST_RDBW) && slot_rsp_valid;

  ows_decide #(.IDX_W(IDX_W)) u_decide (
    .bit_a   (bit_a_q),
    .bit_b   (slot_rsp_bit),
    .pos     (pos),
    .prev    (prev_q),
    .old_bit (old_bit),
    .abort   (abort),
    .choice  (choice),
    .mark    (mark)
  );

  ows_id_store #(.ID_W(ID_W), .IDX_W(IDX_W)) u_id (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (pair_in && !abort),
    .wr_idx (pos),
    .wr_bit (choice),
    .rd_idx (pos),
    .rd_bit (old_bit),
    .id_q   (rom_id)
  );

  ows_disc_track #(.IDX_W(IDX_W)) u_disc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   ((state == ST_IDLE) && start),
    .cap_en  (pair_in && !abort && mark),
    .cap_idx (pos),
    .disc_q  (disc_run)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pos        <= '0;
      prev_q     <= '0;
      bit_a_q    <= 1'b0;
      dir_q      <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      disc_out_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_RST;
          prev_q <= prev_disc;
          pos    <= '0;
          done_q <= 1'b0;
          err_q  <= 1'b0;
        end
        ST_RST:  if (slot_ready)     state <= ST_RSTW;
        ST_RSTW: if (slot_rsp_valid) state <= ST_CMD;
        ST_CMD:  if (slot_ready)     state <= ST_CMDW;
        ST_CMDW: if (slot_rsp_valid) begin
          if (pos == LAST_CMD) begin
            pos   <= '0;
            state <= ST_RDA;
          end else begin
            pos   <= pos + 1'b1;
            state <= ST_CMD;
          end
        end
        ST_RDA:  if (slot_ready) state <= ST_RDAW;
        ST_RDAW: if (slot_rsp_valid) begin
          bit_a_q <= slot_rsp_bit;
          state   <= ST_RDB;
        end
        ST_RDB:  if (slot_ready) state <= ST_RDBW;
        ST_RDBW: if (slot_rsp_valid) begin
          if (abort) begin
            err_q      <= 1'b1;
            done_q     <= 1'b1;
            disc_out_q <= '0;
            state      <= ST_IDLE;
          end else begin
            dir_q <= choice;
            state <= ST_DIR;
          end
        end
        ST_DIR:  if (slot_ready) state <= ST_DIRW;
        ST_DIRW: if (slot_rsp_valid) begin
          if (pos == LAST_POS) begin
            done_q     <= 1'b1;
            disc_out_q <= disc_run;
            state      <= ST_IDLE;
          end else begin
            pos   <= pos + 1'b1;
            state <= ST_RDA;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    slot_valid = 1'b0;
    kind       = SK_RESET;
    case (state)
      ST_RST: slot_valid = 1'b1;
      ST_CMD: begin
        slot_valid = 1'b1;
        kind       = CMD_CODE[pos[CIDX_W-1:0]] ? SK_WR1 : SK_WR0;
      end
      ST_RDA, ST_RDB: begin
        slot_valid = 1'b1;
        kind       = SK_READ;
      end
      ST_DIR: begin
        slot_valid = 1'b1;
        kind       = dir_q ? SK_WR1 : SK_WR0;
      end
      default: ;
    endcase
  end

  assign slot_kind = kind;
  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign next_disc = disc_out_q;
endmodule

// File: rtl/ows_search_chk.sv
module ows_search_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             slot_valid,
  input logic             slot_ready,
  input logic [1:0]       slot_kind,
  input logic [IDX_W-1:0] next_disc
);
  // R11
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid && !slot_ready |=> slot_valid && $stable(slot_kind));

  // R11
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid |-> busy);

  // R4
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && next_disc == '0);

  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R2
  first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> slot_valid && slot_kind == 2'd0);
endmodule

bind ow_rom_search ows_search_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .slot_valid (slot_valid),
  .slot_ready (slot_ready),
  .slot_kind  (slot_kind),
  .next_disc  (next_disc)
);

// File: tb/sim_ow_rom_search.sv
`timescale 1ns/1ps
module sim_ow_rom_search;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [5:0]  prev_disc;
  logic        slot_valid, slot_ready;
  logic [1:0]  slot_kind;
  logic        rsp_valid, rsp_bit;
  logic        busy, done, err;
  logic [63:0] rom_id;
  logic [5:0]  next_disc;

  always #2.5 clk = ~clk;

  ow_rom_search u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .prev_disc(prev_disc),
    .slot_valid(slot_valid), .slot_ready(slot_ready), .slot_kind(slot_kind),
    .slot_rsp_valid(rsp_valid), .slot_rsp_bit(rsp_bit),
    .busy(busy), .done(done), .err(err), .rom_id(rom_id), .next_disc(next_disc)
  );

  int chk_cnt = 0;
  int fail_cnt = 0;

  // modelled bus population
  logic [63:0] dev_rom [4];
  logic [3:0]  dev_on = '0;
  logic [3:0]  dev_act = '0;
  int          dev_pos = 0;
  bit          rd_second = 0;
  int          wr_seen = 0;
  logic [1:0]  slog [256];
  int          scnt = 0;
  int          hold_err = 0;
  logic [1:0]  eng_k;
  logic        eng_rb;

  localparam logic [63:0] BASE = 64'h1234_5678_9ABC_D001;
  localparam logic [63:0] D1 = BASE & ~64'h208;
  localparam logic [63:0] D2 = D1 | 64'h200;
  localparam logic [63:0] D3 = D1 | 64'h8 | 64'hF0000;
  localparam logic [63:0] DA = 64'h5C00_00A1_B2C3_D428;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    chk_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic dev_slot(input logic [1:0] k, output logic rb);
    rb = 1'b0;
    case (k)
      2'd0: begin
        dev_act = dev_on; dev_pos = 0; rd_second = 0; wr_seen = 0;
      end
      2'd1, 2'd2: begin
        if (wr_seen < 8) wr_seen++;
        else begin
          for (int d = 0; d < 4; d++)
            if (dev_act[d] && dev_pos < 64 && dev_rom[d][dev_pos] != (k == 2'd2))
              dev_act[d] = 1'b0;
          dev_pos++;
          rd_second = 0;
        end
      end
      default: begin
        rb = 1'b1;
        for (int d = 0; d < 4; d++)
          if (dev_act[d] && dev_pos < 64)
            rb = rb & (rd_second ? ~dev_rom[d][dev_pos] : dev_rom[d][dev_pos]);
        rd_second = !rd_second;
      end
    endcase
  endtask

  // slot engine with back-pressure and latency
  initial begin
    slot_ready = 1'b0; rsp_valid = 1'b0; rsp_bit = 1'b0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (slot_valid) begin
        eng_k = slot_kind;
        repeat (scnt % 3) begin
          @(negedge clk);
          if (!slot_valid || slot_kind !== eng_k) hold_err++;
        end
        slot_ready = 1'b1;
        @(negedge clk);
        slot_ready = 1'b0;
        if (scnt < 256) slog[scnt] = eng_k;
        scnt++;
        dev_slot(eng_k, eng_rb);
        repeat (scnt % 2) @(negedge clk);
        rsp_valid = 1'b1; rsp_bit = eng_rb;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_bit = 1'b0;
      end
    end
  end

  task automatic run_search(input logic [5:0] pd, input bit poke_busy);
    int t;
    scnt = 0;
    @(negedge clk);
    start = 1'b1; prev_disc = pd;
    @(negedge clk);
    start = 1'b0; prev_disc = 6'd0;
    if (poke_busy) begin
      repeat (6) @(negedge clk);
      start = 1'b1; prev_disc = 6'd9;
      @(negedge clk);
      start = 1'b0; prev_disc = 6'd0;
    end
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 err", 64'(err), 64'd0);
    check("R1 slot_valid", 64'(slot_valid), 64'd0);
    check("R1 rom_id", rom_id, 64'd0);
    check("R1 next_disc", 64'(next_disc), 64'd0);
  endtask

  task automatic t_single;
    dev_rom[0] = DA; dev_on = 4'b0001;
    run_search(6'd0, 1'b0);
    check("R2 reset slot", 64'(slog[0]), 64'd0);
    for (int i = 0; i < 8; i++)
      check("R2 command slot", 64'(slog[1+i]), (i < 4) ? 64'd1 : 64'd2);
    check("R3 read a", 64'(slog[9]), 64'd3);
    check("R3 read b", 64'(slog[10]), 64'd3);
    check("R5 write of pos0", 64'(slog[11]), 64'd1);
    check("R3 slot count", 64'(scnt), 64'd201);
    check("R5 id", rom_id, DA);
    check("R9 family byte", 64'(rom_id[7:0]), 64'h28);
    check("R9 disc none", 64'(next_disc), 64'd0);
    check("R9 done", 64'(done), 64'd1);
    check("R9 err", 64'(err), 64'd0);
  endtask

  task automatic t_three_first;
    dev_rom[0] = D1; dev_rom[1] = D2; dev_rom[2] = D3; dev_on = 4'b0111;
    run_search(6'd0, 1'b1);
    check("R7 first id", rom_id, D1);
    check("R7 first disc", 64'(next_disc), 64'd9);
    check("R10 busy start ignored", 64'(scnt), 64'd201);
  endtask

  task automatic t_nodev;
    dev_on = 4'b0000;
    run_search(6'd17, 1'b0);
    check("R4 err", 64'(err), 64'd1);
    check("R4 done", 64'(done), 64'd1);
    check("R4 disc zero", 64'(next_disc), 64'd0);
    check("R4 slot count", 64'(scnt), 64'd11);
  endtask

  task automatic t_three_rest;
    dev_on = 4'b0111;
    run_search(6'd9, 1'b0);
    check("R8 replay 0 id", rom_id, D2);
    check("R8 replay 0 disc", 64'(next_disc), 64'd3);
    run_search(6'd3, 1'b0);
    check("R6 take 1 id", rom_id, D3);
    check("R9 last device disc", 64'(next_disc), 64'd0);
    run_search(6'd9, 1'b0);
    check("R8 replay 1 id", rom_id, D3);
    check("R8 replay 1 no record", 64'(next_disc), 64'd0);
  endtask

  task automatic t_edges;
    dev_rom[0] = 64'h00FF_0000_0000_1100; dev_rom[1] = 64'h00FF_0000_0000_1101;
    dev_on = 4'b0011;
    run_search(6'd0, 1'b0);
    check("R6 pos0 id", rom_id, 64'h00FF_0000_0000_1101);
    check("R6 pos0 disc", 64'(next_disc), 64'd0);
    dev_rom[0] = 64'h0000_0000_0000_0A10; dev_rom[1] = 64'h8000_0000_0000_0A10;
    run_search(6'd0, 1'b0);
    check("R7 top id", rom_id, 64'h0000_0000_0000_0A10);
    check("R7 top disc", 64'(next_disc), 64'd63);
    run_search(6'd63, 1'b0);
    check("R6 top id", rom_id, 64'h8000_0000_0000_0A10);
    check("R6 top disc", 64'(next_disc), 64'd0);
    check("R11 request held", 64'(hold_err), 64'd0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk_cnt, fail_cnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fail_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; prev_disc = 6'd0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single();
    t_three_first();
    t_nodev();
    t_three_rest();
    t_edges();
    summary();
    $finish;
  end
endmodule